// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where instruction fetch goes next in a 32-bit core with a branch delay slot. Each cycle it receives the current program counter, the fetched instruction word and the value read from the instruction's source register. It decodes four sign-based conditional branches against zero, the region-relative absolute jump, jump-and-link and jump-through-register. From these it produces the next program counter, a redirect flag, and a link-register write request with its value.

The decision path is purely combinational. A parameter can add a program counter register that loads the computed address on every clock and clears on a synchronous active-high reset. With the register enabled, the surrounding fetch logic can feed `pc_q` straight back into `pc_in`.

The register file, the ALU, fetch and hazard handling sit outside this block.

Top module: `npc_unit`

## Requirements
- R1: An instruction with opcode field bits [31:26] = 0x01 and rt field bits [20:16] = 0x00 is a branch-if-negative: `taken` is 1 exactly when bit 31 of `rs_val` is 1.
- R2: Opcode 0x01 with rt field 0x01 is a branch-if-not-negative: `taken` is 1 exactly when bit 31 of `rs_val` is 0, including when `rs_val` is zero.
- R3: Opcode 0x06 with rt field 0x00 is a branch-if-not-positive: `taken` is 1 when `rs_val` is zero or negative.
- R4: Opcode 0x07 with rt field 0x00 is a branch-if-positive: `taken` is 1 only when `rs_val` is nonzero with bit 31 clear.
- R5: For a taken branch, `next_pc` = `pc_in` + 4 + (sign-extended bits [15:0] shifted left by 2). For a branch that is not taken, `next_pc` = `pc_in` + 4. No branch form raises `link_we`.
- R6: Opcode 0x02 is a jump: `next_pc` = {bits [31:28] of `pc_in`+4, instruction bits [25:0], 2'b00}, with `taken` = 1 and `link_we` = 0.
- R7: Opcode 0x03 forms the same target as R6, raises `taken` and `link_we`, and drives `link_val` = `pc_in` + 8.
- R8: Opcode 0x00 with function field bits [5:0] = 0x08 sets `next_pc` = `rs_val`, with `taken` = 1 and `link_we` = 0.
- R9: Any other encoding, including opcode 0x01 with rt above 0x01, opcode 0x06 or 0x07 with a nonzero rt field, and opcode 0x00 with another function field, gives `next_pc` = `pc_in` + 4 with `taken` and `link_we` both 0.
- R10: With the register enabled, `pc_q` becomes `RESET_PC` (0x00000000 by default) on a clock edge while `rst` is 1, and otherwise loads `next_pc` on every rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional PC register and the checks |
| rst | input | 1 | Synchronous active-high reset |
| pc_in | input | 32 | Address of the instruction being resolved |
| instr | input | 32 | Instruction word at `pc_in` |
| rs_val | input | 32 | Value of the register named by bits [25:21] |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | 1 when control leaves the sequential path |
| link_we | output | 1 | Request to write `link_val` into register 31 |
| link_val | output | 32 | Return address, `pc_in` + 8 |
| pc_q | output | 32 | Registered next address (or `next_pc` when the register is disabled) |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a four-bit region kept by absolute jumps, and the PC register enabled. With the register present, every scoreboard item is checked twice: once on the combinational outputs and once on `pc_q` after the edge. This also exercises the reset clear mid-run. The region width lets a jump from 0x7FFFFFFC reach the case where adding 4 carries into the kept upper bits.

// File: rtl/npc_pkg.sv
package npc_pkg;

   // control-flow class of the decoded instruction
   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_BLTZ,
      FLOW_BGEZ,
      FLOW_BLEZ,
      FLOW_BGTZ,
      FLOW_J,
      FLOW_JAL,
      FLOW_JR
   } flow_e;

   localparam int INSTR_W  = 32;
   localparam int OPC_W    = 6;
   localparam int REG_W    = 5;
   localparam int IMM_W    = 16;
   localparam int JIDX_W   = 26;

   localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
   localparam logic [OPC_W-1:0] OPC_REGIMM  = 6'h01;
   localparam logic [OPC_W-1:0] OPC_JUMP    = 6'h02;
   localparam logic [OPC_W-1:0] OPC_JLINK   = 6'h03;
   localparam logic [OPC_W-1:0] OPC_NPOS    = 6'h06;
   localparam logic [OPC_W-1:0] OPC_POS     = 6'h07;
   localparam logic [OPC_W-1:0] FN_JREG     = 6'h08;
   localparam logic [REG_W-1:0] SUB_LTZ     = 5'h00;
   localparam logic [REG_W-1:0] SUB_GEZ     = 5'h01;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output flow_e              flow,
   output logic [IMM_W-1:0]   imm,
   output logic [JIDX_W-1:0]  jidx
);

   logic [OPC_W-1:0] opc;
   logic [REG_W-1:0] sub;
   logic [OPC_W-1:0] fn;

   assign opc  = instr[31:26];
   assign sub  = instr[20:16];
   assign fn   = instr[5:0];
   assign imm  = instr[IMM_W-1:0];
   assign jidx = instr[JIDX_W-1:0];

   always_comb begin
      flow = FLOW_SEQ;
      unique case (opc)
         OPC_REGIMM: begin
            if (sub == SUB_LTZ)      flow = FLOW_BLTZ;
            else if (sub == SUB_GEZ) flow = FLOW_BGEZ;
         end
         OPC_NPOS:    if (sub == '0) flow = FLOW_BLEZ;
         OPC_POS:     if (sub == '0) flow = FLOW_BGTZ;
         OPC_JUMP:    flow = FLOW_J;
         OPC_JLINK:   flow = FLOW_JAL;
         OPC_SPECIAL: if (fn == FN_JREG) flow = FLOW_JR;
         default:     flow = FLOW_SEQ;
      endcase
   end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  flow_e           flow,
   input  logic [XLEN-1:0] rs_val,
   output logic            br_taken
);

   logic neg;
   logic zero;

   assign neg  = rs_val[XLEN-1];
   assign zero = (rs_val == '0);

   always_comb begin
      unique case (flow)
         FLOW_BLTZ: br_taken = neg;
         FLOW_BGEZ: br_taken = ~neg;
         FLOW_BLEZ: br_taken = neg | zero;
         FLOW_BGTZ: br_taken = ~neg & ~zero;
         default:   br_taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int REGION_BITS = 4
) (
   input  logic [XLEN-1:0]   pc,
   input  logic [IMM_W-1:0]  imm,
   input  logic [JIDX_W-1:0] jidx,
   output logic [XLEN-1:0]   pc4,
   output logic [XLEN-1:0]   pc8,
   output logic [XLEN-1:0]   br_tgt,
   output logic [XLEN-1:0]   j_tgt
);

   localparam int EXT_W = XLEN - IMM_W - 2;

   logic [XLEN-1:0] disp;

   assign pc4    = pc + XLEN'(4);
   assign pc8    = pc + XLEN'(8);
   assign disp   = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign br_tgt = pc4 + disp;
   assign j_tgt  = {pc4[XLEN-1 -: REGION_BITS], jidx, 2'b00};

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              REGION_BITS = 4,
   parameter bit              REG_PC      = 1'b1,
   parameter logic [XLEN-1:0] RESET_PC    = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [XLEN-1:0] pc_in,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] rs_val,
   output logic [XLEN-1:0] next_pc,
   output logic            taken,
   output logic            link_we,
   output logic [XLEN-1:0] link_val,
   output logic [XLEN-1:0] pc_q
);

   localparam int JT_W = REGION_BITS + JIDX_W + 2;

   initial begin
      assert (XLEN == INSTR_W) else $error("npc_unit: XLEN must equal the instruction width");
      assert (JT_W == XLEN) else $error("npc_unit: region bits plus jump index must fill a word");
   end

   flow_e             flow;
   logic [IMM_W-1:0]  imm;
   logic [JIDX_W-1:0] jidx;
   logic              br_taken;
   logic [XLEN-1:0]   pc4, pc8, br_tgt, j_tgt;

   npc_decode u_dec (
      .instr (instr),
      .flow  (flow),
      .imm   (imm),
      .jidx  (jidx)
   );

   npc_cond #(.XLEN(XLEN)) u_cond (
      .flow     (flow),
      .rs_val   (rs_val),
      .br_taken (br_taken)
   );

   npc_target #(.XLEN(XLEN), .REGION_BITS(REGION_BITS)) u_tgt (
      .pc     (pc_in),
      .imm    (imm),
      .jidx   (jidx),
      .pc4    (pc4),
      .pc8    (pc8),
      .br_tgt (br_tgt),
      .j_tgt  (j_tgt)
   );

   always_comb begin
      next_pc = pc4;
      taken   = 1'b0;
      link_we = 1'b0;
      unique case (flow)
         FLOW_BLTZ, FLOW_BGEZ, FLOW_BLEZ, FLOW_BGTZ: begin
            taken = br_taken;
            if (br_taken) next_pc = br_tgt;
         end
         FLOW_J: begin
            taken   = 1'b1;
            next_pc = j_tgt;
         end
         FLOW_JAL: begin
            taken   = 1'b1;
            link_we = 1'b1;
            next_pc = j_tgt;
         end
         FLOW_JR: begin
            taken   = 1'b1;
            next_pc = rs_val;
         end
         default: ;
      endcase
   end

   assign link_val = pc8;

   generate
      if (REG_PC) begin : g_pc_reg
         logic [XLEN-1:0] pc_r;
         always_ff @(posedge clk) begin
            if (rst) pc_r <= RESET_PC;
            else     pc_r <= next_pc;
         end
         assign pc_q = pc_r;

         // R10
         pc_load_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> pc_q == $past(next_pc));
         // R10
         pc_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> pc_q == RESET_PC);
      end else begin : g_pc_pass
         assign pc_q = next_pc;
      end
   endgenerate

   // R9
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      !taken |-> (next_pc == pc_in + XLEN'(4) && !link_we));
   // R7
   jal_link_chk: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (taken && link_val == pc_in + XLEN'(8)));
   // R5
   branch_no_link_chk: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OPC_REGIMM || instr[31:26] == OPC_NPOS ||
       instr[31:26] == OPC_POS) |-> !link_we);
   // R8
   jr_target_chk: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OPC_SPECIAL && instr[5:0] == FN_JREG) |->
      (next_pc == rs_val && taken && !link_we));
   // R6
   jump_region_chk: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OPC_JUMP || instr[31:26] == OPC_JLINK) |->
      (next_pc[XLEN-1 -: REGION_BITS] == pc4[XLEN-1 -: REGION_BITS] && taken));

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] npc;
      logic        tk;
      logic        lw;
      logic [31:0] lv;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_in = '0, instr = '0, rs_val = '0;
   logic [31:0] next_pc, link_val, pc_q;
   logic        taken, link_we;

   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   npc_unit uut (
      .clk      (clk),
      .rst      (rst),
      .pc_in    (pc_in),
      .instr    (instr),
      .rs_val   (rs_val),
      .next_pc  (next_pc),
      .taken    (taken),
      .link_we  (link_we),
      .link_val (link_val),
      .pc_q     (pc_q)
   );

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] idx);
      return {op, idx};
   endfunction

   function automatic logic [31:0] enc_r(logic [4:0] rs, logic [5:0] fn);
      return {6'h00, rs, 15'h0, fn};
   endfunction

   function automatic logic [31:0] bdisp(logic [15:0] off);
      return {{14{off[15]}}, off, 2'b00};
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic drive(logic [31:0] pc, logic [31:0] ins, logic [31:0] rv,
                        logic [31:0] npc, logic tk, logic lw, string tag);
      exp_t e;
      @(negedge clk);
      pc_in  = pc;
      instr  = ins;
      rs_val = rv;
      e.npc = npc; e.tk = tk; e.lw = lw; e.lv = pc + 32'd8; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: outputs settle after the negedge drive; pc_q loads at the posedge
   always begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, "next_pc", next_pc, e.npc);
         check(e.tag, "taken", {31'b0, taken}, {31'b0, e.tk});
         check(e.tag, "link_we", {31'b0, link_we}, {31'b0, e.lw});
         if (e.lw) check(e.tag, "link_val", link_val, e.lv);
         check("R10", "pc_q", pc_q, e.npc);
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] pc;
      repeat (3) @(posedge clk);
      #1;
      check("R10", "pc_q after reset", pc_q, 32'h0);
      @(negedge clk);
      rst = 1'b0;

      pc = 32'h0000_1000;
      // R1: branch if negative
      drive(pc, enc_i(6'h01, 5'd3, 5'h00, 16'h0010), 32'hFFFF_FFFF, pc + 4 + bdisp(16'h0010), 1, 0, "R1");
      drive(pc, enc_i(6'h01, 5'd3, 5'h00, 16'h0010), 32'h0000_0005, pc + 4, 0, 0, "R1");
      drive(pc, enc_i(6'h01, 5'd3, 5'h00, 16'h0010), 32'h0, pc + 4, 0, 0, "R1");
      // R2: branch if not negative
      drive(pc, enc_i(6'h01, 5'd4, 5'h01, 16'h0020), 32'h0, pc + 4 + bdisp(16'h0020), 1, 0, "R2");
      drive(pc, enc_i(6'h01, 5'd4, 5'h01, 16'h0020), 32'h8000_0000, pc + 4, 0, 0, "R2");
      // R3: branch if not positive
      drive(pc, enc_i(6'h06, 5'd5, 5'h00, 16'h0003), 32'h0, pc + 4 + bdisp(16'h0003), 1, 0, "R3");
      drive(pc, enc_i(6'h06, 5'd5, 5'h00, 16'h0003), 32'h8000_0001, pc + 4 + bdisp(16'h0003), 1, 0, "R3");
      drive(pc, enc_i(6'h06, 5'd5, 5'h00, 16'h0003), 32'h0000_0001, pc + 4, 0, 0, "R3");
      // R4: branch if positive
      drive(pc, enc_i(6'h07, 5'd6, 5'h00, 16'h0100), 32'h7FFF_FFFF, pc + 4 + bdisp(16'h0100), 1, 0, "R4");
      drive(pc, enc_i(6'h07, 5'd6, 5'h00, 16'h0100), 32'h0, pc + 4, 0, 0, "R4");
      drive(pc, enc_i(6'h07, 5'd6, 5'h00, 16'h0100), 32'h8000_0000, pc + 4, 0, 0, "R4");
      // R5: negative offsets
      drive(pc, enc_i(6'h01, 5'd1, 5'h00, 16'hFFFF), 32'hFFFF_FFF0, pc, 1, 0, "R5");
      drive(32'h0004_0000, enc_i(6'h07, 5'd1, 5'h00, 16'h8000), 32'h1,
            32'h0004_0004 - 32'h0002_0000, 1, 0, "R5");
      // R6: jump, with a carry from pc+4 into the kept upper bits
      drive(32'h7FFF_FFFC, enc_j(6'h02, 26'h123_4567), 32'h0,
            {4'h8, 26'h123_4567, 2'b00}, 1, 0, "R6");
      drive(32'h3000_0010, enc_j(6'h02, 26'h3FF_FFFF), 32'h0,
            {4'h3, 26'h3FF_FFFF, 2'b00}, 1, 0, "R6");
      // R7: jump and link
      drive(32'h1000_0040, enc_j(6'h03, 26'h000_0100), 32'h0,
            {4'h1, 26'h000_0100, 2'b00}, 1, 1, "R7");
      // R8: jump through register
      drive(32'h0000_2000, enc_r(5'd31, 6'h08), 32'hDEAD_BEE0, 32'hDEAD_BEE0, 1, 0, "R8");
      // R9: encodings that must fall through
      drive(pc, enc_i(6'h01, 5'd2, 5'h02, 16'h0040), 32'hFFFF_FFFF, pc + 4, 0, 0, "R9");
      drive(pc, enc_i(6'h06, 5'd2, 5'h01, 16'h0040), 32'h0, pc + 4, 0, 0, "R9");
      drive(pc, enc_i(6'h07, 5'd2, 5'h04, 16'h0040), 32'h5, pc + 4, 0, 0, "R9");
      drive(pc, enc_r(5'd9, 6'h09), 32'h0000_4000, pc + 4, 0, 0, "R9");
      drive(pc, enc_i(6'h08, 5'd2, 5'h03, 16'h0001), 32'h0, pc + 4, 0, 0, "R9");

      // R10: mid-run reset clears the register
      @(posedge clk);
      #1;
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check("R10", "pc_q on reset", pc_q, 32'h0);
      @(negedge clk);
      rst = 1'b0;
      drive(32'h0000_0100, enc_i(6'h08, 5'd0, 5'd0, 16'h0), 32'h0, 32'h0000_0104, 0, 0, "R10");
      @(posedge clk);
      #2;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule